// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Device Controller

This block is the device side of a three-wire serial memory. A host drives a select line, a shift clock and a serial data line. The block answers on a serial output that has its own output-enable. The storage is modelled as on-chip registers that hold all ones after reset. All logic runs on a system clock. The select and shift-clock inputs are edge-detected against that clock, so the shift clock must stay well below the system clock rate.

Every instruction starts with a 1 bit, followed by a two-bit opcode and an address field. A strap input chooses between two word formats: 16-bit words, or 8-bit words with one more address bit. The total storage is the same in both formats. Reads return a 0 marker bit and then the word, most significant bit first. If select stays high, the next words follow with no marker between them.

Programming is blocked until an enable instruction has been received, and stays allowed until a disable instruction arrives. Each write, erase or bulk operation starts a self-timed program cycle whose length in system clocks is a parameter. The host learns the end of the cycle by dropping select and raising it again. The output then shows 0 while the cycle runs and 1 once it has finished.

Top module: `serial_nvm_dev`

## Requirements
- R1: Serial input is sampled on each rising edge of the shift clock while select is high. Zeros before the first 1 are ignored. That 1 is followed by a two-bit opcode, MSB first, and then the address field, MSB first.
- R2: With `wide_i`=1, words are 16 bits and the address field is WADDR_W bits. With `wide_i`=0, words are 8 bits and the address field is WADDR_W+1 bits. A 16-bit word n occupies byte n*2 (upper half) and byte n*2+1 (lower half) of the 8-bit view.
- R3: On a read, the rising edge that carries the last address bit drives a 0 marker on `sdo_o` with `sdo_oe_o`=1. Each following rising edge drives the next data bit, MSB first.
- R4: While select stays high after a read word, the address advances by one and the next word follows directly, with no marker bit. The address wraps from the last word to word 0.
- R5: Opcode 10 reads, 01 writes and 11 erases one word. For opcode 00, the top two address bits choose the action: 11 enables programming, 00 disables it, 10 erases all words and 01 writes one data word to all words.
- R6: Programming is disabled after reset. While it is disabled, a write, erase or bulk instruction leaves the storage unchanged and starts no program cycle. Reads work whether programming is enabled or not.
- R7: Erase sets every bit of the addressed word to 1, and erase-all does so for every word. A write replaces the old contents with no erase needed first.
- R8: Write-all stores the received data word in every word location.
- R9: The program cycle starts right after the last data bit of a write, or the last address bit of an erase. It lasts PROG_CYCLES system clocks. If select falls and rises again during the cycle, `sdo_oe_o`=1 and `sdo_o` shows 0 while the cycle runs and 1 after it ends.
- R10: If select rises only after the program cycle has ended, no status is driven (`sdo_oe_o`=0). While the status is being shown, serial input bits are ignored.
- R11: `sdo_oe_o` is 0 whenever select is low. After reset, every bit of the storage reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in |
| wide_i | input | 1 | Word format strap: 1 = 16-bit words, 0 = 8-bit words |
| sdo_o | output | 1 | Serial data / ready-busy status out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |

## Verification
The hardest case to reach is the status poll. The host must drop select and raise it again inside the program cycle, and only after the instruction has fully landed. The bench times this with a fixed number of system clocks counted from the last data bit. It then shifts extra bits during the poll to show they are ignored. Finally it raises select once more after the cycle has ended and checks that the output stays undriven. A behavioural byte-array model works out every read word, including the wrap from the last word back to 0 and the reads in both word formats of bytes that were written in the other format.

// File: rtl/serial_nvm_pkg.sv
package serial_nvm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_DAT,
      ST_RD,
      ST_DONE
   } nvm_state_t;

   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_ERASE = 2'b11;
   localparam logic [1:0] OP_EXT   = 2'b00;

   localparam logic [1:0] SUB_EN   = 2'b11;
   localparam logic [1:0] SUB_DIS  = 2'b00;
   localparam logic [1:0] SUB_ERAL = 2'b10;
   localparam logic [1:0] SUB_WRAL = 2'b01;

endpackage

// File: rtl/nvm_rise_det.sv
module nvm_rise_det #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_i,
   output logic [N-1:0] rise_o
);
   if (N < 1) begin : g_bad_n
      $error("nvm_rise_det: N must be at least 1");
   end

   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sig_i;
   end

   assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
   parameter int CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("nvm_prog_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left_q <= '0;
      else if (start_i)      left_q <= LOAD;
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign busy_o = (left_q != '0);

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o); // R9
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
   parameter int WADDR_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wide_i,
   input  logic [WADDR_W:0]   rd_addr_i,
   output logic [15:0]        rd_word_o,
   input  logic               wr_go_i,
   input  logic               wr_all_i,
   input  logic [WADDR_W:0]   wr_addr_i,
   input  logic [15:0]        wr_word_i
);
   localparam int BADDR_W = WADDR_W + 1;
   localparam int NBYTES  = 1 << BADDR_W;

   if (WADDR_W < 2 || WADDR_W > 10) begin : g_bad_depth
      $error("nvm_store: WADDR_W out of range");
   end

   logic [7:0] mem [NBYTES];

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      localparam logic [BADDR_W-1:0] IDX = BADDR_W'(i);
      logic       hit;
      logic [7:0] val;
      always_comb begin
         if (wide_i) begin
            hit = wr_all_i || (IDX[BADDR_W-1:1] == wr_addr_i[WADDR_W-1:0]);
            val = IDX[0] ? wr_word_i[7:0] : wr_word_i[15:8];
         end else begin
            hit = wr_all_i || (IDX == wr_addr_i);
            val = wr_word_i[15:8];
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             mem[i] <= 8'hFF;
         else if (wr_go_i && hit) mem[i] <= val;
      end
   end

   always_comb begin
      if (wide_i)
         rd_word_o = {mem[{rd_addr_i[WADDR_W-1:0], 1'b0}],
                      mem[{rd_addr_i[WADDR_W-1:0], 1'b1}]};
      else
         rd_word_o = {mem[rd_addr_i], 8'h00};
   end
endmodule

// File: rtl/serial_nvm_dev.sv
module serial_nvm_dev
   import serial_nvm_pkg::*;
#(
   parameter int WADDR_W     = 6,
   parameter int PROG_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic sdi_i,
   input  logic wide_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   localparam int BADDR_W = WADDR_W + 1;
   localparam logic [4:0] AW_LAST_W = 5'(WADDR_W - 1);
   localparam logic [4:0] AW_LAST_B = 5'(BADDR_W - 1);

   if (WADDR_W < 2 || WADDR_W > 10) begin : g_bad_waddr
      $error("serial_nvm_dev: WADDR_W must be 2..10");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("serial_nvm_dev: PROG_CYCLES must be at least 1");
   end

   // edge detection of select and shift clock
   logic [1:0] rises;
   logic       cs_rise, sck_rise;

   nvm_rise_det #(.N(2)) u_edges (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  ({cs_i, sck_i}),
      .rise_o (rises)
   );
   assign cs_rise  = rises[1];
   assign sck_rise = rises[0] & cs_i;

   // control state
   nvm_state_t           st;
   logic [4:0]           cnt;
   logic [1:0]           opc;
   logic [BADDR_W-1:0]   addr;
   logic [15:0]          shreg;
   logic                 we_q, reading, stat, sdo_q, bulk_q;
   logic                 go_q, all_q;
   logic [BADDR_W-1:0]   waddr_q;
   logic [15:0]          wdata_q;
   logic                 busy;
   logic [15:0]          rd_word;

   // derived combinational values
   logic [4:0]           aw_last, dw_last;
   logic [BADDR_W-1:0]   addr_nx, addr_inc, rd_addr;
   logic [1:0]           sub;
   logic [15:0]          shreg_in, wr_word;

   always_comb begin
      aw_last  = wide_i ? AW_LAST_W : AW_LAST_B;
      dw_last  = wide_i ? 5'd15 : 5'd7;
      addr_nx  = {addr[BADDR_W-2:0], sdi_i};
      addr_inc = wide_i ? {1'b0, addr[WADDR_W-1:0] + 1'b1} : addr + 1'b1;
      sub      = wide_i ? addr_nx[WADDR_W-1 -: 2] : addr_nx[BADDR_W-1 -: 2];
      rd_addr  = (st == ST_ADR) ? addr_nx : addr_inc;
      shreg_in = {shreg[14:0], sdi_i};
      wr_word  = wide_i ? shreg_in : {shreg_in[7:0], 8'h00};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         opc     <= '0;
         addr    <= '0;
         shreg   <= '0;
         we_q    <= 1'b0;
         reading <= 1'b0;
         stat    <= 1'b0;
         sdo_q   <= 1'b0;
         bulk_q  <= 1'b0;
         go_q    <= 1'b0;
         all_q   <= 1'b0;
         waddr_q <= '0;
         wdata_q <= '0;
      end else begin
         go_q <= 1'b0;
         if (!cs_i) begin
            st      <= ST_IDLE;
            reading <= 1'b0;
            stat    <= 1'b0;
         end else begin
            if (cs_rise && busy) stat <= 1'b1;
            if (sck_rise) begin
               unique case (st)
                  ST_IDLE: begin
                     if (sdi_i && !busy && !stat) begin
                        st  <= ST_OPC;
                        cnt <= '0;
                     end
                  end
                  ST_OPC: begin
                     opc <= {opc[0], sdi_i};
                     if (cnt == 5'd1) begin
                        st   <= ST_ADR;
                        cnt  <= '0;
                        addr <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  ST_ADR: begin
                     addr <= addr_nx;
                     cnt  <= cnt + 1'b1;
                     if (cnt == aw_last) begin
                        cnt <= '0;
                        st  <= ST_DONE;
                        unique case (opc)
                           OP_READ: begin
                              st      <= ST_RD;
                              reading <= 1'b1;
                              sdo_q   <= 1'b0;
                              shreg   <= rd_word;
                           end
                           OP_WRITE: begin
                              st     <= ST_DAT;
                              shreg  <= '0;
                              bulk_q <= 1'b0;
                           end
                           OP_ERASE: begin
                              if (we_q) begin
                                 go_q    <= 1'b1;
                                 all_q   <= 1'b0;
                                 waddr_q <= addr_nx;
                                 wdata_q <= '1;
                              end
                           end
                           default: begin
                              unique case (sub)
                                 SUB_EN:  we_q <= 1'b1;
                                 SUB_DIS: we_q <= 1'b0;
                                 SUB_ERAL: begin
                                    if (we_q) begin
                                       go_q    <= 1'b1;
                                       all_q   <= 1'b1;
                                       waddr_q <= addr_nx;
                                       wdata_q <= '1;
                                    end
                                 end
                                 default: begin
                                    st     <= ST_DAT;
                                    shreg  <= '0;
                                    bulk_q <= 1'b1;
                                 end
                              endcase
                           end
                        endcase
                     end
                  end
                  ST_DAT: begin
                     shreg <= shreg_in;
                     if (cnt == dw_last) begin
                        st <= ST_DONE;
                        if (we_q) begin
                           go_q    <= 1'b1;
                           all_q   <= bulk_q;
                           waddr_q <= addr;
                           wdata_q <= wr_word;
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  ST_RD: begin
                     sdo_q <= shreg[15];
                     if (cnt == dw_last) begin
                        cnt   <= '0;
                        addr  <= addr_inc;
                        shreg <= rd_word;
                     end else begin
                        cnt   <= cnt + 1'b1;
                        shreg <= {shreg[14:0], 1'b0};
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   nvm_store #(.WADDR_W(WADDR_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide_i    (wide_i),
      .rd_addr_i (rd_addr),
      .rd_word_o (rd_word),
      .wr_go_i   (go_q),
      .wr_all_i  (all_q),
      .wr_addr_i (waddr_q),
      .wr_word_i (wdata_q)
   );

   nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (go_q),
      .busy_o  (busy)
   );

   assign sdo_o    = stat ? ~busy : sdo_q;
   assign sdo_oe_o = cs_i & (stat | reading);

   AST_PROG_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |-> $past(we_q)); // R6
   AST_NO_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |-> !busy); // R10
   AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat) |-> $past(busy)); // R9
   AST_READ_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reading) |-> !sdo_o); // R3
endmodule

// File: tb/serial_nvm_dev_tb.sv
module serial_nvm_dev_tb;
   localparam int AW16 = 6;
   localparam int PCYC = 60;
   localparam int NB   = 1 << (AW16 + 1);

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, sdi = 1'b0, wide = 1'b1;
   logic sdo, oe;

   int checks = 0, fails = 0, desel_bad = 0;
   bit done = 0;
   bit wen = 0;
   logic [7:0] mdl [NB];

   always #4 clk = ~clk;

   serial_nvm_dev #(.WADDR_W(AW16), .PROG_CYCLES(PCYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
      .wide_i(wide), .sdo_o(sdo), .sdo_oe_o(oe)
   );

   // R11 monitor: output enable must be low on every clock while deselected
   always @(negedge clk) if (rst_n && !cs && oe) desel_bad++;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic waitc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic b, output logic o);
      sdi = b; waitc(4);
      sck = 1'b1; waitc(4);
      o = sdo; sck = 1'b0;
   endtask

   task automatic sel_on();  cs = 1'b1; waitc(2); endtask
   task automatic sel_off(); sck = 1'b0; sdi = 1'b0; cs = 1'b0; waitc(4); endtask

   function automatic int aw(); return wide ? AW16 : AW16 + 1; endfunction
   function automatic int dw(); return wide ? 16 : 8; endfunction
   function automatic int nwords(); return wide ? NB / 2 : NB; endfunction
   function automatic int mword(int a);
      return wide ? {mdl[2*a], mdl[2*a+1]} : int'(mdl[a]);
   endfunction

   task automatic hdr(logic [1:0] op, int a, int lead, output logic last);
      logic o;
      for (int i = 0; i < lead; i++) sbit(1'b0, o);
      sbit(1'b1, o); sbit(op[1], o); sbit(op[0], o);
      for (int i = aw() - 1; i >= 0; i--) sbit(a[i], o);
      last = o;
   endtask

   task automatic rd(int a, int n, int lead, string tag);
      logic o;
      int cur = a;
      sel_on();
      hdr(2'b10, a, lead, o);
      chk(o == 1'b0 && oe == 1'b1, {tag, " marker bit"}, {oe, o}, 2);
      for (int w = 0; w < n; w++) begin
         int got = 0;
         for (int b = 0; b < dw(); b++) begin
            sbit(1'b0, o);
            got = (got << 1) | int'(o);
         end
         chk(got == mword(cur), tag, got, mword(cur));
         cur = (cur + 1) % nwords();
      end
      sel_off();
   endtask

   task automatic model_prog(logic [1:0] op, int a, int data);
      int top = a >> (aw() - 2);
      if (op == 2'b01 || op == 2'b11) begin
         int v = (op == 2'b11) ? 16'hFFFF : data;
         if (wide) begin mdl[2*a] = v[15:8]; mdl[2*a+1] = v[7:0]; end
         else mdl[a] = v[7:0];
      end else if (top == 2) begin
         for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
      end else if (top == 1) begin
         for (int i = 0; i < NB; i++) mdl[i] = wide ? ((i % 2) ? data[7:0] : data[15:8]) : data[7:0];
      end
   endtask

   task automatic prog(logic [1:0] op, int a, int data, bit hasd, string tag);
      logic o;
      sel_on();
      hdr(op, a, 0, o);
      if (hasd) for (int i = dw() - 1; i >= 0; i--) sbit(data[i], o);
      sel_off();
      if (wen) begin
         cs = 1'b1; waitc(3);
         chk(oe == 1'b1 && sdo == 1'b0, {tag, " R9 busy status"}, {oe, sdo}, 2);
         sbit(1'b1, o); sbit(1'b0, o);
         chk(oe == 1'b1 && sdo == 1'b0, {tag, " R10 bits ignored while busy"}, {oe, sdo}, 2);
         waitc(PCYC + 10);
         chk(oe == 1'b1 && sdo == 1'b1, {tag, " R9 ready status"}, {oe, sdo}, 3);
         sel_off();
         cs = 1'b1; waitc(3);
         chk(oe == 1'b0, {tag, " R10 no status after cycle"}, oe, 0);
         sel_off();
         model_prog(op, a, data);
      end else begin
         cs = 1'b1; waitc(3);
         chk(oe == 1'b0, {tag, " R6 no cycle when disabled"}, oe, 0);
         sel_off();
      end
   endtask

   task automatic ctl(bit en);
      logic o;
      sel_on();
      hdr(2'b00, (en ? 3 : 0) << (aw() - 2), 0, o);
      sel_off();
      wen = en;
   endtask

   initial begin
      for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
      waitc(5); rst_n = 1'b1; waitc(3);
      chk(oe == 1'b0, "R11 reset output disabled", oe, 0);
      rd(0, 1, 0, "R11 reset contents ones");
      prog(2'b01, 3, 16'h1234, 1, "R6 write while disabled");
      rd(3, 1, 0, "R6 storage unchanged, read allowed");
      ctl(1);
      prog(2'b01, 3, 16'hA5C3, 1, "R5 write after enable");
      rd(3, 1, 0, "R3 16-bit read");
      wide = 1'b0; waitc(2);
      rd(6, 2, 0, "R2 byte view of word 3");
      prog(2'b01, 6, 8'h5A, 1, "R7 write over data");
      rd(5, 3, 3, "R4 R1 sequential with leading zeros");
      wide = 1'b1; waitc(2);
      prog(2'b11, 3, 0, 0, "R7 erase word");
      rd(3, 1, 0, "R7 erased word");
      prog(2'b01, NB / 2 - 1, 16'h0F0F, 1, "R4 write last word");
      rd(NB / 2 - 1, 2, 0, "R4 wrap to word 0");
      prog(2'b00, 1 << (AW16 - 2), 16'h3C3C, 1, "R8 write all");
      rd(10, 2, 0, "R8 write-all result");
      prog(2'b00, 2 << (AW16 - 2), 0, 0, "R7 erase all");
      rd(10, 1, 0, "R7 erase-all result");
      ctl(0);
      prog(2'b01, 2, 16'h7777, 1, "R5 write after disable");
      rd(2, 1, 0, "R6 disabled write dropped");
      chk(desel_bad == 0, "R11 oe low while deselected", desel_bad, 0);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      waitc(150000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule